// File: doc/BRIEF.md
# Phase Detector Lock Monitor

This block decides whether a phase-locked loop has settled. It watches the UP and DOWN pulses of a phase-frequency detector and measures the phase error of every detector cycle. The error is the number of fast sampling-clock periods during which exactly one of the two pulses is high. A rising edge on the reference input closes one detector cycle and opens the next. At that edge the error just measured is judged against two limits. The tighter limit is used to acquire lock. The looser limit is used to lose it.

The lock flag is active high and has hysteresis. While unlocked, the block counts consecutive cycles whose error is below the acquire limit. It raises the flag when that run reaches three, or five when the run-length select input is high. A single cycle above the drop limit clears the flag. A cycle that falls between the two limits keeps the flag as it is. The flag is meant to feed a chip's multiplexed status pin. Both limits are parameters given in sampling-clock counts.

Top module: `pll_lock_monitor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the lock flag, the run of good cycles and the error accumulator. `lock_o` is 0 on the first sample after reset.
- R2: The error of a detector cycle counts the sampling clocks with `up_i` XOR `dn_i` high. Clocks with both pulses high, or both low, add nothing.
- R3: A cycle runs from one rising edge of `ref_i` to the next, and the sample taken at the edge clock belongs to the new cycle. The partial cycle that ends at the first edge after reset is never judged.
- R4: With `long_run_i` = 0, `lock_o` rises in the clock after the edge that judges the third consecutive good cycle. A good cycle has error < ACQ_LIMIT.
- R5: With `long_run_i` = 1, five consecutive good cycles are needed before `lock_o` rises.
- R6: While unlocked, a judged cycle with error >= ACQ_LIMIT resets the run of good cycles to zero.
- R7: While locked, one judged cycle with error > DROP_LIMIT clears `lock_o`, and the run starts again from zero.
- R8: While locked, a cycle with error from ACQ_LIMIT to DROP_LIMIT inclusive leaves `lock_o` high.
- R9: The limits are exact. An error of ACQ_LIMIT-1 is good and ACQ_LIMIT is not. An error of DROP_LIMIT keeps lock and DROP_LIMIT+1 drops it.
- R10: The accumulator saturates at its all-ones value, so a very long error is still judged as above DROP_LIMIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_smp | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | UP pulse from the phase-frequency detector |
| dn_i | input | 1 | DOWN pulse from the phase-frequency detector |
| ref_i | input | 1 | Reference; its rising edge starts a detector cycle |
| long_run_i | input | 1 | 0: run of 3 good cycles to lock; 1: run of 5 |
| lock_o | output | 1 | Lock flag, active high |

## Verification
On every clock, the embedded properties check these points. The flag moves only at a judging edge. A rise was caused by a good error and a fall by an error above the drop limit. The accumulator restarts at each edge, holds when no single pulse is active, and stays at saturation. The run counter stays in range and is zero while locked. The exact run lengths for both select values cannot be seen from one or two cycles, nor can the restart of the run after a mid-range error or the values at the limit boundaries. Only the bench's scripted cycle sequences can show those, and it compares them against its behavioural model at every clock.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;
   typedef enum logic {
      RUN_SHORT = 1'b0,
      RUN_LONG  = 1'b1
   } run_sel_e;

   function automatic int unsigned run_target(input run_sel_e sel,
                                              input int unsigned short_len,
                                              input int unsigned long_len);
      return (sel == RUN_LONG) ? long_len : short_len;
   endfunction
endpackage

// File: rtl/lockmon_in_stage.sv
module lockmon_in_stage #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_sync
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk) begin
            if (rst) pipe_q <= '0;
            else     pipe_q <= {pipe_q[STAGES-2+((STAGES>1)?0:1):0], d_i};
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lockmon_err_meter.sv
module lockmon_err_meter #(
   parameter int unsigned ERR_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             up_i,
   input  logic             dn_i,
   input  logic             ref_i,
   output logic             eval_o,
   output logic [ERR_W-1:0] err_o
);
   localparam logic [ERR_W-1:0] ACC_MAX = {ERR_W{1'b1}};

   logic             ref_q;
   logic             seen_q;
   logic [ERR_W-1:0] acc_q;
   logic             ref_rise;
   logic             single;

   assign ref_rise = ref_i & ~ref_q;
   assign single   = up_i ^ dn_i;
   assign eval_o   = ref_rise & seen_q;
   assign err_o    = acc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_q  <= 1'b0;
         seen_q <= 1'b0;
         acc_q  <= '0;
      end else begin
         ref_q <= ref_i;
         if (ref_rise) begin
            seen_q <= 1'b1;
            acc_q  <= {{(ERR_W-1){1'b0}}, single};
         end else if (single && (acc_q != ACC_MAX)) begin
            acc_q <= acc_q + 1'b1;
         end
      end
   end

   // R3: a new cycle starts from zero or one
   a_r3_restart: assert property (@(posedge clk) disable iff (rst)
      ref_rise |=> (acc_q <= 1));
   // R2: no single pulse, no growth
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
      (!ref_rise && !(up_i ^ dn_i)) |=> $stable(acc_q));
   // R10: saturated count stays saturated inside a cycle
   a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
      (!ref_rise && acc_q == ACC_MAX) |=> acc_q == ACC_MAX);
endmodule

// File: rtl/lockmon_qualifier.sv
module lockmon_qualifier
   import lockmon_pkg::*;
#(
   parameter int unsigned ERR_W      = 8,
   parameter int unsigned ACQ_LIMIT  = 15,
   parameter int unsigned DROP_LIMIT = 25,
   parameter int unsigned RUN_A      = 3,
   parameter int unsigned RUN_B      = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             eval_i,
   input  logic [ERR_W-1:0] err_i,
   input  logic             long_run_i,
   output logic             lock_o
);
   localparam int unsigned RUN_MAX = (RUN_A > RUN_B) ? RUN_A : RUN_B;
   localparam int unsigned CNT_W   = $clog2(RUN_MAX + 1);

   logic             lock_q;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] need;
   logic [CNT_W-1:0] run_nx;
   logic             good;
   logic             bad;

   assign need   = CNT_W'(run_target(run_sel_e'(long_run_i), RUN_A, RUN_B));
   assign run_nx = run_q + 1'b1;
   assign good   = 32'(err_i) < ACQ_LIMIT;
   assign bad    = 32'(err_i) > DROP_LIMIT;
   assign lock_o = lock_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lock_q <= 1'b0;
         run_q  <= '0;
      end else if (eval_i) begin
         if (!lock_q) begin
            if (!good) begin
               run_q <= '0;
            end else if (run_nx >= need) begin
               lock_q <= 1'b1;
               run_q  <= '0;
            end else begin
               run_q <= run_nx;
            end
         end else if (bad) begin
            lock_q <= 1'b0;
            run_q  <= '0;
         end
      end
   end

   // R4 / R5: the flag moves only at a judging edge
   a_r4_change_on_eval: assert property (@(posedge clk) disable iff (rst)
      !$stable(lock_q) |-> $past(eval_i));
   // R6: acquisition needs a good error
   a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(lock_q) |-> (32'($past(err_i)) < ACQ_LIMIT));
   // R7: loss needs an error above the drop limit
   a_r7_fall_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(lock_q) |-> (32'($past(err_i)) > DROP_LIMIT));
   // R5: run counter in range
   a_r5_run_bound: assert property (@(posedge clk) disable iff (rst)
      32'(run_q) < RUN_MAX);
   // R8: no run is kept while locked
   a_r8_locked_run: assert property (@(posedge clk) disable iff (rst)
      lock_q |-> run_q == '0);
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
   parameter int unsigned ERR_W       = 8,
   parameter int unsigned ACQ_LIMIT   = 15,
   parameter int unsigned DROP_LIMIT  = 25,
   parameter int unsigned RUN_SHORT_N = 3,
   parameter int unsigned RUN_LONG_N  = 5,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk_smp,
   input  logic rst,
   input  logic up_i,
   input  logic dn_i,
   input  logic ref_i,
   input  logic long_run_i,
   output logic lock_o
);
   initial begin : p_param_chk
      assert (ACQ_LIMIT >= 1 && ACQ_LIMIT <= DROP_LIMIT)
         else $fatal(1, "acquire limit must be 1..DROP_LIMIT");
      assert (DROP_LIMIT < (2**ERR_W) - 1)
         else $fatal(1, "ERR_W too small for DROP_LIMIT");
      assert (RUN_SHORT_N >= 1 && RUN_LONG_N >= 1)
         else $fatal(1, "run lengths must be nonzero");
   end

   logic             up_s, dn_s, ref_s;
   logic             eval;
   logic [ERR_W-1:0] err;

   lockmon_in_stage #(.STAGES(SYNC_STAGES)) i_sync_up (
      .clk(clk_smp), .rst(rst), .d_i(up_i), .q_o(up_s));
   lockmon_in_stage #(.STAGES(SYNC_STAGES)) i_sync_dn (
      .clk(clk_smp), .rst(rst), .d_i(dn_i), .q_o(dn_s));
   lockmon_in_stage #(.STAGES(SYNC_STAGES)) i_sync_ref (
      .clk(clk_smp), .rst(rst), .d_i(ref_i), .q_o(ref_s));

   lockmon_err_meter #(.ERR_W(ERR_W)) i_meter (
      .clk(clk_smp), .rst(rst), .up_i(up_s), .dn_i(dn_s), .ref_i(ref_s),
      .eval_o(eval), .err_o(err));

   lockmon_qualifier #(
      .ERR_W(ERR_W), .ACQ_LIMIT(ACQ_LIMIT), .DROP_LIMIT(DROP_LIMIT),
      .RUN_A(RUN_SHORT_N), .RUN_B(RUN_LONG_N)
   ) i_qual (
      .clk(clk_smp), .rst(rst), .eval_i(eval), .err_i(err),
      .long_run_i(long_run_i), .lock_o(lock_o));
endmodule

// File: tb/test_pll_lock_monitor.sv
module test_pll_lock_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int ACQ  = 15;
   localparam int DROP = 25;
   localparam int SATV = 255;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic up = 1'b0, dn = 1'b0, refs = 1'b0, sel = 1'b0;
   logic lock;

   int vectors = 0;
   int miscompares = 0;
   string cur_req = "R1";

   int  m_acc = 0, m_run = 0;
   bit  m_lock = 0, m_prev = 0, m_seen = 0;

   pll_lock_monitor i_pll_lock_monitor (
      .clk_smp(clk), .rst(rst), .up_i(up), .dn_i(dn), .ref_i(refs),
      .long_run_i(sel), .lock_o(lock));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic model_reset();
      m_acc = 0; m_run = 0; m_lock = 0; m_prev = 0; m_seen = 0;
   endtask

   task automatic model_clock(bit u, bit d, bit r, bit s);
      int need;
      need = s ? 5 : 3;
      if (r && !m_prev) begin
         if (m_seen) begin
            if (!m_lock) begin
               if (m_acc < ACQ) begin
                  m_run++;
                  if (m_run >= need) begin m_lock = 1; m_run = 0; end
               end else m_run = 0;
            end else if (m_acc > DROP) begin
               m_lock = 0; m_run = 0;
            end
         end
         m_seen = 1;
         m_acc  = (u != d) ? 1 : 0;
      end else if (u != d && m_acc < SATV) m_acc++;
      m_prev = r;
   endtask

   task automatic check(bit exp, string tag);
      vectors++;
      if (lock !== exp) begin
         miscompares++;
         $display("FAIL %s: lock_o=%0b expected %0b at %0t", tag, lock, exp, $time);
      end
   endtask

   task automatic step(bit u, bit d, bit r);
      up = u; dn = d; refs = r;
      @(posedge clk);
      if (rst) model_reset(); else model_clock(u, d, r, sel);
      @(negedge clk);
      check(m_lock, cur_req);
   endtask

   // kind 0: UP only, 1: DOWN only, 2: both high outside the error window
   task automatic pd_cycle(int err, int len, int kind);
      for (int i = 0; i < len; i++) begin
         bit act;
         act = (i < err);
         case (kind)
            0: step(act, 1'b0, i == 0);
            1: step(1'b0, act, i == 0);
            default: step(1'b1, !act, i == 0);
         endcase
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      step(0, 0, 0);
      step(0, 0, 0);
      rst = 1'b0;
   endtask

   initial begin : p_watchdog
      #(CLK_PERIOD * 150000);
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : p_main
      @(negedge clk);
      cur_req = "R1";
      do_reset();
      check(1'b0, "R1 reset state");

      // R4 and R3: short run, first partial cycle is not judged
      cur_req = "R4"; sel = 1'b0;
      repeat (3) pd_cycle(5, 30, 0);
      check(1'b0, "R3 first cycle unjudged");
      pd_cycle(5, 30, 1);
      check(1'b1, "R4 lock after three good cycles");

      // R8 / R9 hysteresis band and limits
      cur_req = "R8";
      pd_cycle(20, 40, 0);
      pd_cycle(DROP, 40, 1);
      pd_cycle(DROP + 1, 40, 0);
      check(1'b1, "R8 mid-band and DROP_LIMIT keep lock");
      cur_req = "R7";
      pd_cycle(5, 40, 0);
      check(1'b0, "R7 R9 DROP_LIMIT+1 drops lock");

      // R6: bad cycle restarts the run
      cur_req = "R6";
      pd_cycle(5, 30, 0);
      pd_cycle(ACQ, 30, 0);
      pd_cycle(5, 30, 0);
      pd_cycle(5, 30, 0);
      pd_cycle(ACQ - 1, 30, 1);
      check(1'b0, "R6 run restarted after ACQ_LIMIT error");
      pd_cycle(5, 30, 0);
      check(1'b1, "R9 ACQ_LIMIT-1 counts as good");

      // R5: long run
      cur_req = "R5";
      do_reset();
      sel = 1'b1;
      repeat (5) pd_cycle(3, 20, 0);
      check(1'b0, "R5 four judged cycles not enough");
      pd_cycle(3, 20, 1);
      check(1'b1, "R5 lock after five good cycles");

      // R2: both-high periods are not error
      cur_req = "R2";
      do_reset();
      sel = 1'b0;
      repeat (4) pd_cycle(4, 40, 2);
      check(1'b1, "R2 overlap not counted as error");

      // R10: saturation still judged as bad
      cur_req = "R10";
      pd_cycle(290, 300, 0);
      pd_cycle(2, 20, 0);
      check(1'b0, "R10 saturated error drops lock");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule